// File: doc/BRIEF.md
# Cross-Clock Mailbox Register Pair

This block moves single control words between two ports that run on unrelated clocks, outside of any data queue. Port A (on `clk_a`) posts words into the first mail register, which port B reads. Port B (on `clk_b`) posts words into the second mail register, which port A reads. Each port presents the same four strobes: a select, a write/read direction, an enable and a mailbox select. A transfer takes place only on a clock edge where all of them call for it.

Each mail register has an active-low full flag in its writer's clock domain. A low flag means the word has not been read yet. While the flag is low, the writer cannot overwrite the word. A read at the other port releases the flag after the read crosses two synchronizer flops. A read does not consume the data: the word stays in the register until the next accepted write. Each port's data output is a multiplexer. When the mailbox select is high it shows the mail register that port reads. When the mailbox select is low it shows the port's FIFO output register, which is an input to this block.

Top module: `xclk_mailbox`

## Requirements
- R1: On a `clk_a` rising edge with `a_sel`, `a_write`, `a_en` and `a_mbx` all 1 and `a_mail_full_n` 1, `a_din` is stored in the first mail register, and `a_mail_full_n` reads 0 right after that edge.
- R2: On a `clk_b` rising edge with `b_sel`, `b_write`, `b_en` and `b_mbx` all 1 and `b_mail_full_n` 1, `b_din` is stored in the second mail register, and `b_mail_full_n` reads 0 right after that edge.
- R3: A write attempt made while the target register's full flag is 0 leaves the register contents and the flag unchanged.
- R4: A write attempt with any one of select, write, enable or mailbox select at 0 does not change the mail register or its flag.
- R5: A port-B read (`b_sel`=1, `b_write`=0, `b_en`=1, `b_mbx`=1) of a full first register sets `a_mail_full_n` to 1. It stays 0 after the first `clk_a` rising edge that follows the read edge, and it is 1 after the second.
- R6: A port-A read (`a_sel`=1, `a_write`=0, `a_en`=1, `a_mbx`=1) of a full second register sets `b_mail_full_n` to 1 within a few `clk_b` cycles.
- R7: A read with mailbox select 0 or enable 0, or a read of a register that holds no unread word, does not change either flag.
- R8: A mail register keeps its contents through any number of reads and changes only on an accepted write.
- R9: `a_dout` equals the second mail register when `a_mbx` is 1 and `a_fifo_q` when `a_mbx` is 0. `b_dout` equals the first mail register when `b_mbx` is 1 and `b_fifo_q` when `b_mbx` is 0.
- R10: While `rst_n` is 0, both flags are 1 and both mail registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| a_sel | input | 1 | Port A select |
| a_write | input | 1 | Port A direction, 1 = write, 0 = read |
| a_en | input | 1 | Port A transfer enable |
| a_mbx | input | 1 | Port A mailbox select |
| a_din | input | 36 | Port A write data |
| a_fifo_q | input | 36 | Port A FIFO output register |
| a_dout | output | 36 | Port A read data |
| a_mail_full_n | output | 1 | First mail register full flag, low = unread |
| b_sel | input | 1 | Port B select |
| b_write | input | 1 | Port B direction, 1 = write, 0 = read |
| b_en | input | 1 | Port B transfer enable |
| b_mbx | input | 1 | Port B mailbox select |
| b_din | input | 36 | Port B write data |
| b_fifo_q | input | 36 | Port B FIFO output register |
| b_dout | output | 36 | Port B read data |
| b_mail_full_n | output | 1 | Second mail register full flag, low = unread |

## Verification
A sequence of posts and reads alternates between the two directions. It includes repeated writes into a full register and repeated reads of an empty one, which separates accepted transfers from locked-out ones. Single-strobe-missing writes and reads show that every qualifier gates the transfer. A read timed against the writer clock shows whether the flag rises exactly two writer edges after the read, rather than one edge early or late. Flipping the mailbox select with no transfer tells the mail path apart from the FIFO path, and it shows that looking at the word does not consume it.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int MAIL_W      = 36;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic wr;
        logic rd;
    } port_req_t;

    function automatic port_req_t decode_req(
        input logic sel,
        input logic write,
        input logic en,
        input logic mbx
    );
        port_req_t r;
        r.wr = sel & en & mbx & write;
        r.rd = sel & en & mbx & ~write;
        return r;
    endfunction

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
    parameter int W      = 36,
    parameter int STAGES = 2
) (
    input  logic         wclk,
    input  logic         rclk,
    input  logic         rst_n,
    input  logic         wr_req,
    input  logic [W-1:0] wr_data,
    input  logic         rd_req,
    output logic         full_n,
    output logic [W-1:0] mail
);

    typedef struct packed {
        logic         tog;
        logic [W-1:0] data;
    } wside_t;

    wside_t wside_d, wside_q;
    logic   rtog_d, rtog_q;
    logic   rtog_s, wtog_s;
    logic   w_full, r_full, wr_take, rd_take;

    mbx_sync #(.STAGES(STAGES)) u_rd_to_w (
        .clk(wclk), .rst_n(rst_n), .d(rtog_q), .q(rtog_s)
    );

    mbx_sync #(.STAGES(STAGES)) u_wr_to_r (
        .clk(rclk), .rst_n(rst_n), .d(wside_q.tog), .q(wtog_s)
    );

    // writer domain
    always_comb begin
        w_full  = wside_q.tog ^ rtog_s;
        wr_take = wr_req & ~w_full;
        wside_d = wside_q;
        if (wr_take) begin
            wside_d.data = wr_data;
            wside_d.tog  = ~wside_q.tog;
        end
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) wside_q <= '0;
        else        wside_q <= wside_d;
    end

    // reader domain
    always_comb begin
        r_full  = wtog_s ^ rtog_q;
        rd_take = rd_req & r_full;
        rtog_d  = rtog_q ^ rd_take;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) rtog_q <= 1'b0;
        else        rtog_q <= rtog_d;
    end

    assign full_n = ~w_full;
    assign mail   = wside_q.data;

    // R1
    wr_accept_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_req && full_n) |=> (!full_n && mail == $past(wr_data)));

    // R3
    wr_lock_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_req && !full_n) |=> (!full_n && $stable(mail)));

    // R8
    data_hold_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        !(wr_req && full_n) |=> $stable(mail));

    // R5
    rd_release_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_req && r_full) |=> !r_full);

endmodule

// File: rtl/mbx_port_mux.sv
module mbx_port_mux #(
    parameter int W = 36
) (
    input  logic         use_mail,
    input  logic [W-1:0] mail,
    input  logic [W-1:0] fifo_q,
    output logic [W-1:0] dout
);

    always_comb begin
        dout = use_mail ? mail : fifo_q;
    end

endmodule

// File: rtl/xclk_mailbox.sv
module xclk_mailbox
    import mbx_pkg::*;
#(
    parameter int W      = MAIL_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic         rst_n,
    input  logic         a_sel,
    input  logic         a_write,
    input  logic         a_en,
    input  logic         a_mbx,
    input  logic [W-1:0] a_din,
    input  logic [W-1:0] a_fifo_q,
    output logic [W-1:0] a_dout,
    output logic         a_mail_full_n,
    input  logic         b_sel,
    input  logic         b_write,
    input  logic         b_en,
    input  logic         b_mbx,
    input  logic [W-1:0] b_din,
    input  logic [W-1:0] b_fifo_q,
    output logic [W-1:0] b_dout,
    output logic         b_mail_full_n
);

    port_req_t a_req, b_req;
    logic [W-1:0] mail_ab, mail_ba;

    always_comb begin
        a_req = decode_req(a_sel, a_write, a_en, a_mbx);
        b_req = decode_req(b_sel, b_write, b_en, b_mbx);
    end

    mbx_channel #(.W(W), .STAGES(STAGES)) u_a_to_b (
        .wclk(clk_a), .rclk(clk_b), .rst_n(rst_n),
        .wr_req(a_req.wr), .wr_data(a_din), .rd_req(b_req.rd),
        .full_n(a_mail_full_n), .mail(mail_ab)
    );

    mbx_channel #(.W(W), .STAGES(STAGES)) u_b_to_a (
        .wclk(clk_b), .rclk(clk_a), .rst_n(rst_n),
        .wr_req(b_req.wr), .wr_data(b_din), .rd_req(a_req.rd),
        .full_n(b_mail_full_n), .mail(mail_ba)
    );

    mbx_port_mux #(.W(W)) u_mux_a (
        .use_mail(a_mbx), .mail(mail_ba), .fifo_q(a_fifo_q), .dout(a_dout)
    );

    mbx_port_mux #(.W(W)) u_mux_b (
        .use_mail(b_mbx), .mail(mail_ab), .fifo_q(b_fifo_q), .dout(b_dout)
    );

endmodule

// File: tb/xclk_mailbox_bench.sv
module xclk_mailbox_bench;

    localparam int W = 36;
    localparam logic [W-1:0] FIFO_A = 36'hA_A0A0_A0A0;
    localparam logic [W-1:0] FIFO_B = 36'hB_B0B0_B0B0;

    logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
    logic a_sel = 0, a_write = 0, a_en = 0, a_mbx = 1;
    logic b_sel = 0, b_write = 0, b_en = 0, b_mbx = 1;
    logic [W-1:0] a_din = '0, b_din = '0;
    logic [W-1:0] a_dout, b_dout;
    logic a_mail_full_n, b_mail_full_n;

    always #10 clk_a = ~clk_a;   // 50 MHz
    always #15 clk_b = ~clk_b;

    xclk_mailbox u_xclk_mailbox (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .a_sel(a_sel), .a_write(a_write), .a_en(a_en), .a_mbx(a_mbx),
        .a_din(a_din), .a_fifo_q(FIFO_A), .a_dout(a_dout),
        .a_mail_full_n(a_mail_full_n),
        .b_sel(b_sel), .b_write(b_write), .b_en(b_en), .b_mbx(b_mbx),
        .b_din(b_din), .b_fifo_q(FIFO_B), .b_dout(b_dout),
        .b_mail_full_n(b_mail_full_n)
    );

    int checks = 0, errors = 0;
    bit reported = 0;

    typedef struct packed {
        logic         port_b;
        logic         is_rd;
        logic [W-1:0] data;
        logic         f1;
        logic         f2;
        logic [W-1:0] m1;
        logic [W-1:0] m2;
    } vec_t;

    localparam vec_t TABLE [11] = '{
        '{1'b0, 1'b0, 36'h1_2345_6789, 1'b0, 1'b1, 36'h1_2345_6789, 36'h0},
        '{1'b0, 1'b0, 36'hF_0000_000F, 1'b0, 1'b1, 36'h1_2345_6789, 36'h0},
        '{1'b1, 1'b1, 36'h0,           1'b1, 1'b1, 36'h1_2345_6789, 36'h0},
        '{1'b1, 1'b1, 36'h0,           1'b1, 1'b1, 36'h1_2345_6789, 36'h0},
        '{1'b1, 1'b0, 36'h8_ABCD_EF01, 1'b1, 1'b0, 36'h1_2345_6789, 36'h8_ABCD_EF01},
        '{1'b1, 1'b0, 36'h7_7777_7777, 1'b1, 1'b0, 36'h1_2345_6789, 36'h8_ABCD_EF01},
        '{1'b0, 1'b1, 36'h0,           1'b1, 1'b1, 36'h1_2345_6789, 36'h8_ABCD_EF01},
        '{1'b0, 1'b0, 36'hF_FFFF_FFFF, 1'b0, 1'b1, 36'hF_FFFF_FFFF, 36'h8_ABCD_EF01},
        '{1'b1, 1'b1, 36'h0,           1'b1, 1'b1, 36'hF_FFFF_FFFF, 36'h8_ABCD_EF01},
        '{1'b1, 1'b0, 36'h0_0000_0001, 1'b1, 1'b0, 36'hF_FFFF_FFFF, 36'h0_0000_0001},
        '{1'b0, 1'b1, 36'h0,           1'b1, 1'b1, 36'hF_FFFF_FFFF, 36'h0_0000_0001}
    };

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic a_op(input logic s, input logic w, input logic e, input logic m,
                        input logic [W-1:0] d);
        @(negedge clk_a);
        a_sel = s; a_write = w; a_en = e; a_mbx = m; a_din = d;
        @(posedge clk_a);
        #1;
        a_sel = 0; a_write = 0; a_en = 0; a_mbx = 1;
    endtask

    task automatic b_op(input logic s, input logic w, input logic e, input logic m,
                        input logic [W-1:0] d);
        @(negedge clk_b);
        b_sel = s; b_write = w; b_en = e; b_mbx = m; b_din = d;
        @(posedge clk_b);
        #1;
        b_sel = 0; b_write = 0; b_en = 0; b_mbx = 1;
    endtask

    task automatic summary;
        if (!reported) begin
            reported = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [W-1:0] m1;
        // R10 reset state
        #95;
        chk("R10 flag1", {35'b0, a_mail_full_n}, 36'h1);
        chk("R10 flag2", {35'b0, b_mail_full_n}, 36'h1);
        chk("R10 mail2", a_dout, '0);
        chk("R10 mail1", b_dout, '0);
        rst_n = 1'b1;
        #100;

        foreach (TABLE[i]) begin
            if (TABLE[i].port_b) b_op(1, !TABLE[i].is_rd, 1, 1, TABLE[i].data);
            else                 a_op(1, !TABLE[i].is_rd, 1, 1, TABLE[i].data);
            #300;
            chk("R1 R3 R5 R7 flag1", {35'b0, a_mail_full_n}, {35'b0, TABLE[i].f1});
            chk("R2 R3 R6 R7 flag2", {35'b0, b_mail_full_n}, {35'b0, TABLE[i].f2});
            chk("R8 mail1", b_dout, TABLE[i].m1);
            chk("R8 mail2", a_dout, TABLE[i].m2);
        end

        // R4: each missing qualifier blocks the write
        a_op(0, 1, 1, 1, 36'h1_1111_1111);
        a_op(1, 1, 0, 1, 36'h2_2222_2222);
        a_op(1, 1, 1, 0, 36'h3_3333_3333);
        b_op(1, 1, 1, 0, 36'h4_4444_4444);
        #300;
        chk("R4 flag1", {35'b0, a_mail_full_n}, 36'h1);
        chk("R4 mail1", b_dout, 36'hF_FFFF_FFFF);
        chk("R4 flag2", {35'b0, b_mail_full_n}, 36'h1);
        chk("R4 mail2", a_dout, 36'h0_0000_0001);

        // R1 immediate flag, R5 release timing
        a_op(1, 1, 1, 1, 36'h5_A5A5_5A5A);
        chk("R1 flag1 after edge", {35'b0, a_mail_full_n}, 36'h0);
        #300;
        m1 = 36'h5_A5A5_5A5A;
        chk("R1 mail1", b_dout, m1);

        // R7: reads missing mbx or enable leave the flag low
        b_op(1, 0, 1, 0, '0);
        b_op(1, 0, 0, 1, '0);
        #300;
        chk("R7 flag1 held", {35'b0, a_mail_full_n}, 36'h0);

        // R9: output mux selection without transfer
        b_mbx = 0; a_mbx = 0;
        #1;
        chk("R9 b fifo", b_dout, FIFO_B);
        chk("R9 a fifo", a_dout, FIFO_A);
        b_mbx = 1; a_mbx = 1;
        #1;
        chk("R9 b mail", b_dout, m1);

        b_op(1, 0, 1, 1, '0);
        @(posedge clk_a); #1;
        chk("R5 flag1 after 1 edge", {35'b0, a_mail_full_n}, 36'h0);
        @(posedge clk_a); #1;
        chk("R5 flag1 after 2 edges", {35'b0, a_mail_full_n}, 36'h1);
        chk("R8 mail1 after read", b_dout, m1);

        // R2 immediate flag, R6 release
        b_op(1, 1, 1, 1, 36'h6_0F0F_F0F0);
        chk("R2 flag2 after edge", {35'b0, b_mail_full_n}, 36'h0);
        #300;
        a_op(1, 0, 1, 1, '0);
        #300;
        chk("R6 flag2", {35'b0, b_mail_full_n}, 36'h1);
        chk("R8 mail2 after read", a_dout, 36'h6_0F0F_F0F0);

        summary();
        $finish;
    end

endmodule